// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block drives and samples a 32-pin general-purpose port through a small word-addressed register window. Software gives each pin one of three roles: a driven output, a plain input, or an input that can raise an interrupt. An interrupt-capable pin picks its own trigger from four choices: rising transition, falling transition, high level or low level.

Pin inputs pass through a two-flop synchronizer. Transitions are found by comparing the synchronized value with its value one cycle earlier. Detected events latch into a pending register, and software clears that register bit by bit by writing ones. Every pending bit of a pin that is in interrupt mode feeds one shared interrupt request.

The register window has a single write strobe. Read data is combinational from the address and has no side effects. The map is:

| Address | Name | Access | Meaning |
|---|---|---|---|
| 0 | drive enable | read/write | 1 = pin is driven |
| 1 | interrupt enable | read/write | 1 = pin may interrupt |
| 2 | trigger, pins 0-15 | read/write | 2 bits per pin |
| 3 | trigger, pins 16-31 | read/write | 2 bits per pin |
| 4 | output data | read/write | value driven on output pins |
| 5 | input data | read only | synchronized pin value |
| 6 | pending | write 1 to clear | latched interrupt events |
| 7 | unmapped | — | reads zero |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, every pin is an undriven input with interrupts disabled, and irq_o is low.
- R2: gpio_oe_o equals the drive-enable register (address 0, 1 = driven). gpio_o equals the output-data register (address 4). A write to either register shows on the pins in the cycle after the write edge.
- R3: Address 5 returns each pin's value sampled through two flops. A change on gpio_i made between two clock edges is still unseen after the first of the next two edges and is visible after the second. Writes to address 5 have no effect.
- R4: A pin is in interrupt mode only when its interrupt-enable bit (address 1) is 1 and its drive-enable bit is 0. A pin that is not in interrupt mode never sets its pending bit.
- R5: Pin p's trigger field sits at bits [2p+1:2p] of address 2 for p < 16, and at bits [2(p-16)+1:2(p-16)] of address 3 for p ≥ 16. The codes are 00 rising, 01 falling, 10 high level, 11 low level.
- R6: On an edge-triggered pin, the pending bit sets on the clock edge after the synchronized value makes the selected transition. The bit then stays set after the pin returns to its old value, until it is cleared.
- R7: On a level-triggered pin, the pending bit is set on every clock edge while the synchronized level matches. A clear written while the level persists leaves the bit at 1.
- R8: Writing to address 6 clears each pending bit whose data bit is 1 and leaves the other bits unchanged.
- R9: irq_o is high exactly when at least one pin is in interrupt mode and also has its pending bit set.
- R10: A write to address 7 changes no register, and a read of address 7 returns zero.
- R11: Addresses 0 to 4 read back the last value written, and a write takes effect on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 3 | register word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i (combinational) |
| gpio_i | input | 32 | pin input values (asynchronous) |
| gpio_o | output | 32 | pin output values |
| gpio_oe_o | output | 32 | pin drive enables |
| irq_o | output | 1 | shared interrupt request |

## Verification
The assertions assume that gpio_i is sampled cleanly on each edge and that wr_en_i and addr_i are valid whenever the clock rises. The bench therefore changes pins and the register strobe only on falling edges. The checks on synchronizer latency and on level holding assume that the pins change only between edges. They also assume that software alone clears pending bits. Directed phases place pin toggles at known cycle offsets from configuration writes. A randomized phase then mixes writes to every address, including the unmapped one, with random pin activity. Every pin role and trigger code is reached through valid register writes only.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_LOW  = 2'b11
  } trig_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_OE      = 3'd0,
    REG_IE      = 3'd1,
    REG_TRIG_LO = 3'd2,
    REG_TRIG_HI = 3'd3,
    REG_DOUT    = 3'd4,
    REG_DIN     = 3'd5,
    REG_PEND    = 3'd6,
    REG_NONE    = 3'd7
  } reg_addr_e;

  function automatic logic trig_hit(logic [1:0] sel, logic cur, logic old);
    case (trig_e'(sel))
      TRIG_RISE: trig_hit = cur & ~old;
      TRIG_FALL: trig_hit = ~cur & old;
      TRIG_HIGH: trig_hit = cur;
      default:   trig_hit = ~cur;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NPINS-1:0]     wdata_i,
  input  logic [NPINS-1:0]     din_i,
  input  logic [NPINS-1:0]     pend_i,
  output logic [NPINS-1:0]     oe_o,
  output logic [NPINS-1:0]     ie_o,
  output logic [2*NPINS-1:0]   trig_o,
  output logic [NPINS-1:0]     dout_o,
  output logic [NPINS-1:0]     clr_o,
  output logic [NPINS-1:0]     rdata_o
);
  logic [NPINS-1:0] oe_q, ie_q, dout_q, trig_lo_q, trig_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q      <= '0;
      ie_q      <= '0;
      dout_q    <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_OE:      oe_q      <= wdata_i;
        REG_IE:      ie_q      <= wdata_i;
        REG_TRIG_LO: trig_lo_q <= wdata_i;
        REG_TRIG_HI: trig_hi_q <= wdata_i;
        REG_DOUT:    dout_q    <= wdata_i;
        default:     ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && addr_i == REG_PEND) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_OE:      rdata_o = oe_q;
      REG_IE:      rdata_o = ie_q;
      REG_TRIG_LO: rdata_o = trig_lo_q;
      REG_TRIG_HI: rdata_o = trig_hi_q;
      REG_DOUT:    rdata_o = dout_q;
      REG_DIN:     rdata_o = din_i;
      REG_PEND:    rdata_o = pend_i;
      default:     rdata_o = '0;
    endcase
  end

  assign oe_o   = oe_q;
  assign ie_o   = ie_q;
  assign dout_o = dout_q;
  assign trig_o = {trig_hi_q, trig_lo_q};
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NPINS-1:0]     sync_i,
  input  logic [NPINS-1:0]     oe_i,
  input  logic [NPINS-1:0]     ie_i,
  input  logic [2*NPINS-1:0]   trig_i,
  input  logic [NPINS-1:0]     clr_i,
  output logic [NPINS-1:0]     pend_o,
  output logic                 irq_o
);
  logic [NPINS-1:0] prev_q, pend_q, hit, irq_mode;

  assign irq_mode = ie_i & ~oe_i;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign hit[p] = trig_hit(trig_i[2*p +: 2], sync_i[p], prev_q[p]);
  end

  // set wins over clear so a held level keeps its bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= (pend_q & ~clr_i) | (hit & irq_mode);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & irq_mode);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       gpio_i,
  output logic [31:0]       gpio_o,
  output logic [31:0]       gpio_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0]   oe_q, ie_q, dout_q, sync_q, pend_q, pend_clr;
  logic [2*NPINS-1:0] trig_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (sync_q)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .din_i  (sync_q),
    .pend_i (pend_q),
    .oe_o   (oe_q),
    .ie_o   (ie_q),
    .trig_o (trig_q),
    .dout_o (dout_q),
    .clr_o  (pend_clr),
    .rdata_o(rdata_o)
  );

  gpio_irq_unit #(.NPINS(NPINS)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_q),
    .oe_i  (oe_q),
    .ie_i  (ie_q),
    .trig_i(trig_q),
    .clr_i (pend_clr),
    .pend_o(pend_q),
    .irq_o (irq_o)
  );

  assign gpio_o    = dout_q;
  assign gpio_oe_o = oe_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [2:0]         addr_i,
  input logic [31:0]        gpio_i,
  input logic [31:0]        gpio_oe_o,
  input logic               irq_o,
  input logic [NPINS-1:0]   oe_q,
  input logic [NPINS-1:0]   ie_q,
  input logic [2*NPINS-1:0] trig_q,
  input logic [NPINS-1:0]   sync_q,
  input logic [NPINS-1:0]   pend_q
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  a_r3_two_flop_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (sync_q == $past(gpio_i, 2)));

  a_r2_oe_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && addr_i == 3'd0) |-> $stable(gpio_oe_o));

  a_r4_no_pend_when_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & $past(oe_q)) == '0);

  a_r8_pend_falls_by_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_q) & ~pend_q)) |-> $past(wr_en_i && addr_i == 3'd6));

  a_r9_irq_has_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|pend_q));

  for (genvar p = 0; p < NPINS; p++) begin : g_lvl
    a_r7_level_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(ie_q[p] && !oe_q[p] && trig_q[2*p +: 2] == 2'b10 && sync_q[p]) |-> pend_q[p]);
    a_r7_level_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(ie_q[p] && !oe_q[p] && trig_q[2*p +: 2] == 2'b11 && !sync_q[p]) |-> pend_q[p]);
  end
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .gpio_i   (gpio_i),
  .gpio_oe_o(gpio_oe_o),
  .irq_o    (irq_o),
  .oe_q     (oe_q),
  .ie_q     (ie_q),
  .trig_q   (trig_q),
  .sync_q   (sync_q),
  .pend_q   (pend_q)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] gpio_o, gpio_oe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_i(pins),
    .gpio_o(gpio_o), .gpio_oe_o(gpio_oe), .irq_o(irq)
  );

  // behavioural reference state
  logic [31:0] m_oe, m_ie, m_tlo, m_thi, m_dout, m_pend;
  logic [31:0] m_p1, m_p2, m_old;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe = 0; m_ie = 0; m_tlo = 0; m_thi = 0; m_dout = 0; m_pend = 0;
      m_p1 = 0; m_p2 = 0; m_old = 0;
    end else begin
      logic [31:0] nxt;
      nxt = m_pend;
      if (wr_en && addr == 3'd6) nxt = nxt & ~wdata;
      for (int p = 0; p < 32; p++) begin
        int code;
        bit ev;
        code = (p < 16) ? ((m_tlo >> (2*p)) & 3) : ((m_thi >> (2*(p-16))) & 3);
        case (code)
          0: ev = m_p2[p] && !m_old[p];
          1: ev = !m_p2[p] && m_old[p];
          2: ev = m_p2[p];
          default: ev = !m_p2[p];
        endcase
        if (ev && m_ie[p] && !m_oe[p]) nxt[p] = 1'b1;
      end
      m_pend = nxt;
      m_old = m_p2; m_p2 = m_p1; m_p1 = pins;
      if (wr_en) begin
        case (addr)
          3'd0: m_oe = wdata;
          3'd1: m_ie = wdata;
          3'd2: m_tlo = wdata;
          3'd3: m_thi = wdata;
          3'd4: m_dout = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #8;
    if (rst_n && !done) begin
      logic [31:0] exp_rd;
      case (addr)
        3'd0: exp_rd = m_oe;
        3'd1: exp_rd = m_ie;
        3'd2: exp_rd = m_tlo;
        3'd3: exp_rd = m_thi;
        3'd4: exp_rd = m_dout;
        3'd5: exp_rd = m_p2;
        3'd6: exp_rd = m_pend;
        default: exp_rd = 0;
      endcase
      chk("R2 gpio_o model", gpio_o, m_dout);
      chk("R2 gpio_oe_o model", gpio_oe, m_oe);
      chk("R9 irq_o model", {31'd0, irq}, {31'd0, |(m_pend & m_ie & ~m_oe)});
      chk("R11 rdata model", rdata, exp_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #8;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    pins = 32'h0000_00F0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) if (a != 5) rd("R1 reset reg", 3'(a), 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    chk("R1 oe after reset", gpio_oe, 32'h0);

    // R11 and R5 readback
    wr(3'd2, 32'h1234_ABCD); rd("R5 trig lo readback", 3'd2, 32'h1234_ABCD);
    wr(3'd3, 32'hFEDC_0123); rd("R5 trig hi readback", 3'd3, 32'hFEDC_0123);
    wr(3'd1, 32'h0000_0000); wr(3'd2, 0); wr(3'd3, 0);

    // R2 pins follow registers
    wr(3'd0, 32'hFFFF_0000);
    chk("R2 oe pins", gpio_oe, 32'hFFFF_0000);
    wr(3'd4, 32'hA5A5_5A5A);
    chk("R2 out pins", gpio_o, 32'hA5A5_5A5A);
    wr(3'd0, 0);

    // R3 two-flop latency and read-only
    @(negedge clk); pins = 32'h0000_0F00; addr = 3'd5;
    @(negedge clk); rd("R3 din after one edge", 3'd5, 32'h0000_00F0);
    @(negedge clk); rd("R3 din after two edges", 3'd5, 32'h0000_0F00);
    wr(3'd5, 32'hFFFF_FFFF); rd("R3 din write ignored", 3'd5, 32'h0000_0F00);
    pins = 0; repeat (3) @(negedge clk);

    // R6 rising edge on pin 3
    wr(3'd1, 32'h0000_0018);
    wr(3'd2, 32'h0000_0100);          // pin 4 falling (code 01 at bits 9:8)
    pins[3] = 1'b1; addr = 3'd6;
    @(negedge clk); @(negedge clk); rd("R6 pend not yet", 3'd6, 32'h0);
    @(negedge clk); rd("R6 pend set on rise", 3'd6, 32'h8);
    chk("R9 irq high", {31'd0, irq}, 32'h1);
    pins[3] = 1'b0; repeat (4) @(negedge clk);
    rd("R6 pend held after return", 3'd6, 32'h8);
    wr(3'd6, 32'hFFFF_FFF7); rd("R8 zero bit keeps", 3'd6, 32'h8);
    wr(3'd6, 32'h8); rd("R8 one bit clears", 3'd6, 32'h0);
    chk("R9 irq low", {31'd0, irq}, 32'h0);

    // R6 falling on pin 4
    pins[4] = 1'b1; repeat (4) @(negedge clk);
    rd("R6 no pend on rise for falling trig", 3'd6, 32'h0);
    pins[4] = 1'b0; repeat (3) @(negedge clk);
    rd("R6 falling sets pend", 3'd6, 32'h10);
    wr(3'd6, 32'h10);

    // R7 level high on pin 7
    wr(3'd1, 32'h0000_0080);
    wr(3'd2, 32'h0000_8000);          // code 10 at bits 15:14
    pins[7] = 1'b1; repeat (3) @(negedge clk);
    rd("R7 level sets", 3'd6, 32'h80);
    wr(3'd6, 32'h80); rd("R7 clear ignored while high", 3'd6, 32'h80);
    pins[7] = 1'b0; repeat (4) @(negedge clk);
    wr(3'd6, 32'h80); rd("R7 clear after level gone", 3'd6, 32'h0);

    // R4 driven pin with enable set never pends
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h0000_0200); wr(3'd0, 32'h0000_0200);
    pins[9] = 1'b1; repeat (4) @(negedge clk);
    pins[9] = 1'b0; repeat (4) @(negedge clk);
    rd("R4 driven pin no pend", 3'd6, 32'h0);
    chk("R4 irq stays low", {31'd0, irq}, 32'h0);
    wr(3'd0, 0); wr(3'd1, 0);

    // R10 unmapped address
    wr(3'd4, 32'h0BAD_F00D);
    wr(3'd7, 32'hFFFF_FFFF);
    rd("R10 unmapped reads zero", 3'd7, 32'h0);
    rd("R10 dout untouched", 3'd4, 32'h0BAD_F00D);

    // randomized mix against the model
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 3) == 0);
      addr = 3'($urandom_range(0, 7));
      wdata = $urandom();
      if ($urandom_range(0, 2) == 0) pins = pins ^ $urandom();
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule